// File: doc/BRIEF.md
# Byte Insert, Extract and Mask Unit

This block carries out the byte-field manipulation steps of a 64-bit integer pipeline. From a byte offset it either places a narrow field of operand A at a byte position (insert), pulls a field out of A from a byte position (extract), or clears a field inside A at a byte position (mask). Each operation has a low form, which works from the offset upward, and a high form, which works with the complement of the offset. The high form handles the part of a field that crosses into the next 64-bit word.

The byte offset comes either from a second 64-bit operand or from an 8-bit immediate. The field width is byte, word, longword or quadword. A request is presented with `in_valid`. The result appears on `result` one clock later, together with `out_valid`. Decode, register file access and the other arithmetic functions sit outside this block.

Top module: `bxm_unit`

## Requirements
- R1: The byte offset is bits [2:0] of `b`, or bits [2:0] of `imm` zero-extended when `imm_sel` is 1. It is scaled by 8 into a bit shift `s` of 0 to 56. The other bits of `b` and `imm` do not affect the result.
- R2: `size` selects the field mask F: 2'b00 gives 0xFF, 2'b01 gives 0xFFFF, 2'b10 gives 0xFFFFFFFF and 2'b11 gives all ones.
- R3: Insert low (`op`=2'b00, `hi`=0) gives (A & F) << s.
- R4: Insert high (`op`=2'b00, `hi`=1) gives (A & F) >> (64 - s). When s is 0 it gives zero.
- R5: Extract low (`op`=2'b01, `hi`=0) gives (A >> s) & F.
- R6: Extract high (`op`=2'b01, `hi`=1) gives (A << (64 - s)) & F. When s is 0, A is not shifted and the result is A & F.
- R7: Mask low (`op`=2'b10, `hi`=0) gives A & ~(F << s). It never sets a bit that is clear in A.
- R8: Mask high (`op`=2'b10, `hi`=1) gives A & ~(F >> (64 - s)). When s is 0, A passes through unchanged.
- R9: `op`=2'b11 is reserved and gives a zero result.
- R10: `out_valid` equals `in_valid` delayed by one clock. `result` loads only when `in_valid` was 1 and otherwise holds its value.
- R11: A synchronous active-high `rst` clears `result` and `out_valid` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | Operation class: insert, extract, mask, reserved |
| size | input | 2 | Field size code |
| hi | input | 1 | 1 selects the high form |
| imm_sel | input | 1 | 1 takes the offset from `imm` |
| a | input | 64 | Operand A |
| b | input | 64 | Operand B, offset source |
| imm | input | 8 | Immediate offset source |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Registered result |

## Verification
The hardest situations are the high forms at offset zero and the fields that are partly shifted off the word edge. In these cases the complement shift of 64 would be out of range, so the special rules in R4, R6 and R8 decide the result. The vector table places word and longword fields at offsets 6 and 7 and runs every high form with an offset of zero. Other vectors set the upper bits of `b` or the immediate to values that would change the result if they leaked into the offset. Directed steps then test the hold behaviour and a reset that arrives while a request is valid.

// File: rtl/bxm_pkg.sv
package bxm_pkg;
  typedef enum logic [1:0] {
    OP_INS = 2'b00,
    OP_EXT = 2'b01,
    OP_MSK = 2'b10,
    OP_RSV = 2'b11
  } bxm_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_QUAD = 2'b11
  } bxm_size_e;

  localparam int NUM_SIZES = 4;
endpackage

// File: rtl/bxm_shift_calc.sv
module bxm_shift_calc #(
  parameter int DATA_W = 64,
  localparam int BYTES = DATA_W / 8,
  localparam int OFS_W = $clog2(BYTES),
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [OFS_W-1:0]  ofs,
  input  bxm_pkg::bxm_size_e size,
  output logic [SH_W-1:0]   sh,
  output logic [SH_W-1:0]   csh,
  output logic              sh_zero,
  output logic [DATA_W-1:0] fmask
);
  logic [DATA_W-1:0] masks [bxm_pkg::NUM_SIZES];

  for (genvar s = 0; s < bxm_pkg::NUM_SIZES; s++) begin : g_sz
    localparam int FW = ((8 << s) > DATA_W) ? DATA_W : (8 << s);
    if (FW >= DATA_W) begin : g_full
      assign masks[s] = '1;
    end else begin : g_part
      assign masks[s] = (DATA_W'(1) << FW) - DATA_W'(1);
    end
  end

  // bit shift = byte offset * 8; complement is (DATA_W - sh) mod DATA_W
  assign sh      = {ofs, 3'b000};
  assign csh     = SH_W'(0) - sh;
  assign sh_zero = (ofs == '0);
  assign fmask   = masks[size];
endmodule

// File: rtl/bxm_datapath.sv
module bxm_datapath #(
  parameter int DATA_W = 64,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  a,
  input  bxm_pkg::bxm_op_e   op,
  input  logic               hi,
  input  logic [SH_W-1:0]    sh,
  input  logic [SH_W-1:0]    csh,
  input  logic               sh_zero,
  input  logic [DATA_W-1:0]  fmask,
  output logic [DATA_W-1:0]  res
);
  logic [DATA_W-1:0] a_fld;
  logic [DATA_W-1:0] ins_lo, ins_hi;
  logic [DATA_W-1:0] ext_lo, ext_hi;
  logic [DATA_W-1:0] msk_lo, msk_hi;

  assign a_fld = a & fmask;

  always_comb begin
    ins_lo = a_fld << sh;
    ins_hi = sh_zero ? '0 : (a_fld >> csh);
    ext_lo = (a >> sh) & fmask;
    ext_hi = (sh_zero ? a : (a << csh)) & fmask;
    msk_lo = a & ~(fmask << sh);
    msk_hi = sh_zero ? a : (a & ~(fmask >> csh));
  end

  always_comb begin
    unique case (op)
      bxm_pkg::OP_INS: res = hi ? ins_hi : ins_lo;
      bxm_pkg::OP_EXT: res = hi ? ext_hi : ext_lo;
      bxm_pkg::OP_MSK: res = hi ? msk_hi : msk_lo;
      default:         res = '0;
    endcase
  end
endmodule

// File: rtl/bxm_unit.sv
module bxm_unit #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic [1:0]        size,
  input  logic              hi,
  input  logic              imm_sel,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [IMM_W-1:0]  imm,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int BYTES = DATA_W / 8;
  localparam int OFS_W = $clog2(BYTES);
  localparam int SH_W  = $clog2(DATA_W);

  logic [DATA_W-1:0] opb;
  logic [SH_W-1:0]   sh, csh;
  logic              sh_zero;
  logic [DATA_W-1:0] fmask;
  logic [DATA_W-1:0] res_c;

  assign opb = imm_sel ? DATA_W'(imm) : b;

  bxm_shift_calc #(.DATA_W(DATA_W)) u_calc (
    .ofs     (opb[OFS_W-1:0]),
    .size    (bxm_pkg::bxm_size_e'(size)),
    .sh      (sh),
    .csh     (csh),
    .sh_zero (sh_zero),
    .fmask   (fmask)
  );

  bxm_datapath #(.DATA_W(DATA_W)) u_dp (
    .a       (a),
    .op      (bxm_pkg::bxm_op_e'(op)),
    .hi      (hi),
    .sh      (sh),
    .csh     (csh),
    .sh_zero (sh_zero),
    .fmask   (fmask),
    .res     (res_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= res_c;
    end
  end
endmodule

// File: rtl/bxm_unit_chk.sv
module bxm_unit_chk #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        op,
  input logic [1:0]        size,
  input logic              hi,
  input logic              imm_sel,
  input logic [DATA_W-1:0] a,
  input logic [DATA_W-1:0] b,
  input logic [IMM_W-1:0]  imm,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);
  localparam int OFS_W = $clog2(DATA_W / 8);

  logic [OFS_W-1:0] ofs_in;
  assign ofs_in = imm_sel ? imm[OFS_W-1:0] : b[OFS_W-1:0];

  // R11
  rst_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (result == '0 && !out_valid));

  // R10
  vld_lat_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> $stable(result));

  // R4
  ins_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid && op == 2'b00 && hi && ofs_in == '0))
      |-> (result == '0));

  // R8
  msk_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid && op == 2'b10 && hi && ofs_in == '0))
      |-> (result == $past(a)));

  // R7
  msk_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid && op == 2'b10))
      |-> ((result & ~$past(a)) == '0));

  // R9
  rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid && op == 2'b11)) |-> (result == '0));

  // R2
  ext_width_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid && op == 2'b01 && size == 2'b00))
      |-> (result[DATA_W-1:8] == '0));
endmodule

bind bxm_unit bxm_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) chk_i (.*);

// File: tb/bxm_unit_tb_top.sv
`timescale 1ns/1ps
module bxm_unit_tb_top;
  typedef struct packed {
    logic [7:0]  rq;
    logic [1:0]  op;
    logic [1:0]  sz;
    logic        hi;
    logic        isel;
    logic [7:0]  imm;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
  } vec_t;

  localparam logic [63:0] AV = 64'h0123456789ABCDEF;
  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{8'd3, 2'd0, 2'd0, 1'b0, 1'b0, 8'h00, AV, 64'h3, 64'h00000000EF000000},          // R3
    '{8'd3, 2'd0, 2'd1, 1'b0, 1'b0, 8'h00, AV, 64'h7, 64'hEF00000000000000},          // R3
    '{8'd4, 2'd0, 2'd1, 1'b1, 1'b0, 8'h00, AV, 64'h7, 64'h00000000000000CD},          // R4
    '{8'd4, 2'd0, 2'd2, 1'b1, 1'b0, 8'h00, AV, 64'h0, 64'h0},                         // R4
    '{8'd4, 2'd0, 2'd3, 1'b1, 1'b0, 8'h00, AV, 64'h3, 64'h0000000000012345},          // R4
    '{8'd5, 2'd1, 2'd1, 1'b0, 1'b0, 8'h00, AV, 64'h2, 64'h00000000000089AB},          // R5
    '{8'd5, 2'd1, 2'd2, 1'b0, 1'b0, 8'h00, AV, 64'h5, 64'h0000000000012345},          // R5
    '{8'd5, 2'd1, 2'd3, 1'b0, 1'b0, 8'h00, AV, 64'h0, AV},                            // R5
    '{8'd6, 2'd1, 2'd1, 1'b1, 1'b0, 8'h00, AV, 64'h7, 64'h000000000000EF00},          // R6
    '{8'd6, 2'd1, 2'd3, 1'b1, 1'b0, 8'h00, AV, 64'h0, AV},                            // R6
    '{8'd7, 2'd2, 2'd0, 1'b0, 1'b0, 8'h00, AV, 64'h1, 64'h0123456789AB00EF},          // R7
    '{8'd7, 2'd2, 2'd2, 1'b0, 1'b0, 8'h00, AV, 64'h6, 64'h0000456789ABCDEF},          // R7
    '{8'd8, 2'd2, 2'd1, 1'b1, 1'b0, 8'h00, AV, 64'h7, 64'h0123456789ABCD00},          // R8
    '{8'd8, 2'd2, 2'd3, 1'b1, 1'b0, 8'h00, AV, 64'h3, 64'h0123456789000000},          // R8
    '{8'd8, 2'd2, 2'd0, 1'b1, 1'b0, 8'h00, AV, 64'h0, AV},                            // R8
    '{8'd9, 2'd3, 2'd1, 1'b0, 1'b0, 8'h00, AV, 64'h2, 64'h0},                         // R9
    '{8'd1, 2'd0, 2'd0, 1'b0, 1'b1, 8'hFD, AV, 64'h0, 64'h0000EF0000000000},          // R1
    '{8'd1, 2'd1, 2'd0, 1'b0, 1'b0, 8'h05, AV, 64'hFFFFFFFFFFFFFF02, 64'h00000000000000AB}, // R1
    '{8'd2, 2'd1, 2'd2, 1'b0, 1'b0, 8'h00, AV, 64'h0, 64'h0000000089ABCDEF}           // R2
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op = '0;
  logic [1:0]  size = '0;
  logic        hi = 1'b0;
  logic        imm_sel = 1'b0;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic [7:0]  imm = '0;
  logic        out_valid;
  logic [63:0] result;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bxm_unit #(.DATA_W(64), .IMM_W(8)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size(size), .hi(hi),
    .imm_sel(imm_sel), .a(a), .b(b), .imm(imm), .out_valid(out_valid), .result(result)
  );

  task automatic chk(input int rq, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL R%0d actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic send(input vec_t v);
    @(negedge clk);
    op = v.op; size = v.sz; hi = v.hi; imm_sel = v.isel;
    imm = v.imm; a = v.a; b = v.b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(11, {63'd0, out_valid}, 64'd0);
    chk(11, result, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(10, {63'd0, out_valid}, 64'd0); // R10 idle

    for (int i = 0; i < NV; i++) begin
      send(TBL[i]);
      chk(10, {63'd0, out_valid}, 64'd1); // R10 latency
      chk(int'(TBL[i].rq), result, TBL[i].exp);
    end

    // R10: result holds while in_valid is low
    send('{8'd3, 2'd0, 2'd0, 1'b0, 1'b0, 8'h00, AV, 64'h2, 64'h0000000000EF0000});
    chk(3, result, 64'h0000000000EF0000);
    op = 2'd2; a = '1; b = 64'h4;
    @(negedge clk);
    chk(10, result, 64'h0000000000EF0000);
    chk(10, {63'd0, out_valid}, 64'd0);

    // R1: immediate offset 0 overrides b offset 3 for insert high (zero result)
    send('{8'd1, 2'd0, 2'd1, 1'b1, 1'b1, 8'hF8, AV, 64'h3, 64'h0});
    chk(1, result, 64'h0);

    // R11: reset while a request is valid
    @(negedge clk);
    op = 2'd1; size = 2'd3; hi = 1'b0; imm_sel = 1'b0; a = AV; b = 64'h0;
    in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    chk(11, result, 64'h0);
    chk(11, {63'd0, out_valid}, 64'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule